// File: doc/BRIEF.md
# Polarity-Configurable Level Interrupt Controller

This block gathers thirty-two level-sensitive interrupt lines and merges them into one cascaded request for a parent interrupt controller. Every line is first brought into the local clock domain, then compared against its own polarity bit so that either an active-high or an active-low wire counts as asserted. An asserted line sets a latched pending bit. Software clears pending bits by writing ones, and it decides through a per-source enable mask and a single global gate which pending bits may raise the cascade output.

Software reaches the block over a plain 32-bit register bus with separate read and write strobes and a one-cycle registered read path. Source numbers run from the most significant bit downwards. A handler reads the pending register, services the sources it finds and acknowledges them, and repeats until the read returns zero. Because the sources are level-triggered, a line that is still held asserted after its acknowledge reappears as pending straight away.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: The block serves 32 sources; source n (input pin irq_src[n]) occupies bit 31-n of the pending, enable, polarity and input-sample registers, so source 0 is bit 31.
- R2: Register offsets on bus_addr: 0x50 pending status (write ones to clear), 0x54 per-source enable, 0x58 polarity, 0x5C input sample (read only), 0x04 global cascade gate (bit 0 only; the other bits read as zero).
- R3: A polarity bit of 0 makes a high level count as asserted; a polarity bit of 1 makes a low level count as asserted.
- R4: Writing 1 to a pending bit clears it, writing 0 leaves it unchanged, and writing 0xFFFFFFFF clears every pending bit whose source is no longer asserted.
- R5: A pending bit sets on every clock in which its polarity-adjusted input is asserted; if a clearing write and an asserted input fall in the same cycle the bit stays set, and a source still asserted after its acknowledge is pending again.
- R6: All registers reset to 0 under the synchronous active-high reset, so every source starts disabled and the cascade output starts low.
- R7: irq_out is a register that goes high one clock after some pending bit is also enabled while gate bit 0 is 1, and is low whenever the gate or every enabled pending bit was 0 on the previous clock.
- R8: Each input passes two synchroniser flops; the input-sample register shows these synchronised raw levels before polarity is applied, and a pending bit sets at the third rising edge after its input becomes asserted.
- R9: bus_rdata presents the addressed register one clock after bus_rd; a write to the enable, polarity or gate register takes effect at that clock edge, and a read issued in the next cycle returns the written value.
- R10: Writes to unmapped offsets change no register, and reads from unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | 32 | Asynchronous level interrupt lines, index = source number |
| bus_addr | input | 8 | Byte offset of the register being accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_rd |
| irq_out | output | 1 | Registered cascade interrupt to the parent controller |

## Verification
The acknowledge write and the re-assertion of a still-active source can land on the same clock, and the pending bit must then survive. The bench holds a source asserted so its pending bit is being set on every cycle, issues the clearing write for that bit, and reads the pending register back expecting the bit still set; it then releases the line, waits for the synchroniser to drain, and confirms that the same write now clears the bit. A second case clears one of two latched sources with a partial mask to show that the zero bits of the write leave the other pending bit alone.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_GATE  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_PEND  = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h54;
  localparam logic [ADDR_W-1:0] OFS_POL   = 8'h58;
  localparam logic [ADDR_W-1:0] OFS_LEVEL = 8'h5C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_GATE,
    SEL_PEND,
    SEL_MASK,
    SEL_POL,
    SEL_LEVEL
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_GATE:  return SEL_GATE;
      OFS_PEND:  return SEL_PEND;
      OFS_MASK:  return SEL_MASK;
      OFS_POL:   return SEL_POL;
      OFS_LEVEL: return SEL_LEVEL;
      default:   return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/lirq_sync.sv
module lirq_sync #(
  parameter int NUM_SRC     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_SRC-1:0] level_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [NUM_SRC-1:0] stage_q [SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < SYNC_STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= src_i;
      for (int k = 1; k < SYNC_STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  // Source n lands on register bit NUM_SRC-1-n.
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_rev
    assign level_o[NUM_SRC-1-n] = stage_q[LAST][n];
  end
endmodule

// File: rtl/lirq_pend.sv
module lirq_pend #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] level_i,
  input  logic [NUM_SRC-1:0] pol_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] asserted;
  logic [NUM_SRC-1:0] pend_q;

  // Polarity 1 flips a low wire into an asserted one.
  assign asserted = level_i ^ pol_i;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_i) | asserted;
  end

  assign pend_o = pend_q;

  // R4: a clear with no competing assertion empties the bit.
  p_clear_takes_r4: assert property (@(posedge clk) disable iff (rst)
    (pend_q & $past(clr_i & ~asserted)) == '0);

  // R5: an asserted source is always pending on the following clock.
  p_level_sets_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(asserted) & ~pend_q) == '0);
endmodule

// File: rtl/lirq_regs.sv
module lirq_regs
  import lirq_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  input  logic               rd_i,
  input  logic [NUM_SRC-1:0] level_i,
  input  logic [NUM_SRC-1:0] pend_i,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [NUM_SRC-1:0] pol_o,
  output logic               gate_o,
  output logic [NUM_SRC-1:0] clr_o,
  output logic [NUM_SRC-1:0] rdata_o
);
  reg_sel_e           sel;
  logic               mapped;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] pol_q;
  logic               gate_q;
  logic [NUM_SRC-1:0] rmux;
  logic [NUM_SRC-1:0] rdata_q;

  assign sel    = decode_addr(addr_i);
  assign mapped = (sel != SEL_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      pol_q  <= '0;
      gate_q <= 1'b0;
    end else if (wr_i) begin
      case (sel)
        SEL_MASK: mask_q <= wdata_i;
        SEL_POL:  pol_q  <= wdata_i;
        SEL_GATE: gate_q <= wdata_i[0];
        default:  ;
      endcase
    end
  end

  assign clr_o = (wr_i && sel == SEL_PEND) ? wdata_i : '0;

  always_comb begin
    rmux = '0;
    case (sel)
      SEL_GATE:  rmux[0] = gate_q;
      SEL_PEND:  rmux = pend_i;
      SEL_MASK:  rmux = mask_q;
      SEL_POL:   rmux = pol_q;
      SEL_LEVEL: rmux = level_i;
      default:   rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_q <= '0;
    else if (rd_i) rdata_q <= rmux;
  end

  assign mask_o  = mask_q;
  assign pol_o   = pol_q;
  assign gate_o  = gate_q;
  assign rdata_o = rdata_q;

  // R10: a read of a hole returns zero.
  p_hole_reads_zero_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rd_i && !mapped) |-> rdata_q == '0);

  // R9: the enable register holds exactly what was written last cycle.
  p_mask_written_r9: assert property (@(posedge clk) disable iff (rst)
    $past(wr_i && sel == SEL_MASK) |-> mask_q == $past(wdata_i));

  // R10: a write to a hole leaves the configuration alone.
  p_hole_write_inert_r10: assert property (@(posedge clk) disable iff (rst)
    $past(wr_i && !mapped) |-> ($stable(mask_q) && $stable(pol_q) && $stable(gate_q)));
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lirq_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [NUM_SRC-1:0] bus_wdata,
  input  logic               bus_rd,
  output logic [NUM_SRC-1:0] bus_rdata,
  output logic               irq_out
);
  logic [NUM_SRC-1:0] level;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] mask;
  logic [NUM_SRC-1:0] pol;
  logic [NUM_SRC-1:0] clr;
  logic               gate;
  logic               irq_q;

  lirq_sync #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .src_i   (irq_src),
    .level_o (level)
  );

  lirq_pend #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .level_i (level),
    .pol_i   (pol),
    .clr_i   (clr),
    .pend_o  (pend)
  );

  lirq_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .addr_i  (bus_addr),
    .wr_i    (bus_wr),
    .wdata_i (bus_wdata),
    .rd_i    (bus_rd),
    .level_i (level),
    .pend_i  (pend),
    .mask_o  (mask),
    .pol_o   (pol),
    .gate_o  (gate),
    .clr_o   (clr),
    .rdata_o (bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= gate & (|(pend & mask));
  end

  assign irq_out = irq_q;

  // R7: a closed gate keeps the cascade quiet.
  p_gate_closed_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(gate) |-> !irq_out);

  // R7: nothing enabled and pending means no cascade request.
  p_nothing_enabled_r7: assert property (@(posedge clk) disable iff (rst)
    $past((pend & mask) == '0) |-> !irq_out);
endmodule

// File: tb/sim_lvl_irq_ctrl.sv
module sim_lvl_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_src = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  lvl_irq_ctrl u0 (
    .clk(clk), .rst(rst), .irq_src(irq_src), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  function automatic logic [31:0] bitof(input int src);
    return 32'h1 << (31 - src);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R6 irq_out after reset", {31'b0, irq_out}, 32'h0);
    bus_read(8'h54, v); check("R6 enable reset", v, 32'h0);
    bus_read(8'h58, v); check("R6 polarity reset", v, 32'h0);
    bus_read(8'h04, v); check("R6 gate reset", v, 32'h0);
    bus_read(8'h50, v); check("R6 pending reset", v, 32'h0);
  endtask

  task automatic t_mapping_sync();
    logic [31:0] v;
    irq_src = 32'h0000_0001;
    @(negedge clk); @(negedge clk);
    bus_read(8'h5C, v); check("R1 R8 source 0 on bit 31", v, 32'h8000_0000);
    irq_src = 32'h0000_0005;
    settle();
    bus_read(8'h5C, v); check("R1 sources 0 and 2", v, bitof(0) | bitof(2));
    bus_write(8'h58, 32'hFFFF_FFFF);
    bus_read(8'h5C, v); check("R8 sample ignores polarity", v, bitof(0) | bitof(2));
    bus_write(8'h58, 32'h0);
    irq_src = '0;
    settle();
    bus_write(8'h50, 32'hFFFF_FFFF);
    bus_read(8'h50, v); check("R4 all-ones clears", v, 32'h0);
  endtask

  task automatic t_sync_latency();
    logic [31:0] v;
    // Change input right after a negedge; status sets on the third posedge.
    @(negedge clk);
    irq_src = 32'h0000_0100;          // source 8
    @(negedge clk); @(negedge clk);   // two edges: sync only
    bus_addr = 8'h50; bus_rd = 1'b1;  // read captures at third edge, pre-update
    @(negedge clk); bus_rd = 1'b0;
    check("R8 not pending after two edges", bus_rdata, 32'h0);
    bus_read(8'h50, v); check("R8 pending after three edges", v, bitof(8));
    irq_src = '0;
    settle();
    bus_write(8'h50, bitof(8));
  endtask

  task automatic t_polarity();
    logic [31:0] v;
    bus_write(8'h58, bitof(12));      // source 12 active low, line is low
    settle();
    bus_read(8'h50, v); check("R3 low level with polarity 1", v, bitof(12));
    irq_src[12] = 1'b1;
    settle();
    bus_write(8'h50, bitof(12));
    bus_read(8'h50, v); check("R3 high level with polarity 1 inactive", v, 32'h0);
    bus_write(8'h58, 32'h0);
    settle();
    bus_write(8'h50, 32'hFFFF_FFFF);
    bus_read(8'h50, v); check("R3 high level with polarity 0", v, bitof(12));
    irq_src = '0;
    settle();
    bus_write(8'h50, 32'hFFFF_FFFF);
  endtask

  task automatic t_clear_partial();
    logic [31:0] v;
    irq_src[4] = 1'b1; irq_src[20] = 1'b1;
    settle();
    irq_src = '0;
    settle();
    bus_write(8'h50, 32'h0);
    bus_read(8'h50, v); check("R4 zero write keeps both", v, bitof(4) | bitof(20));
    bus_write(8'h50, bitof(4));
    bus_read(8'h50, v); check("R4 partial clear", v, bitof(20));
    bus_write(8'h50, 32'hFFFF_FFFF);
    bus_read(8'h50, v); check("R4 full clear", v, 32'h0);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    irq_src[5] = 1'b1;
    settle();
    bus_write(8'h50, bitof(5));
    bus_read(8'h50, v); check("R5 set wins over clear", v, bitof(5));
    irq_src[5] = 1'b0;
    settle();
    bus_read(8'h50, v); check("R5 stays latched after release", v, bitof(5));
    bus_write(8'h50, bitof(5));
    bus_read(8'h50, v); check("R5 clears once released", v, 32'h0);
  endtask

  task automatic t_cascade();
    logic [31:0] v;
    irq_src[3] = 1'b1;
    settle();
    check("R6 disabled source no cascade", {31'b0, irq_out}, 32'h0);
    bus_write(8'h04, 32'h1);
    @(negedge clk);
    check("R7 gate open, mask zero", {31'b0, irq_out}, 32'h0);
    bus_write(8'h54, bitof(3));
    check("R7 not yet high at write edge", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    check("R7 high one clock after enable", {31'b0, irq_out}, 32'h1);
    bus_write(8'h54, bitof(9));
    @(negedge clk);
    check("R6 other source enabled only", {31'b0, irq_out}, 32'h0);
    bus_write(8'h54, bitof(3));
    bus_write(8'h04, 32'h0);
    @(negedge clk);
    check("R7 gate closed", {31'b0, irq_out}, 32'h0);
    bus_write(8'h04, 32'hFFFF_FFFF);
    bus_read(8'h04, v); check("R2 gate reads bit 0 only", v, 32'h1);
    irq_src = '0;
    settle();
    bus_write(8'h50, 32'hFFFF_FFFF);
    @(negedge clk); @(negedge clk);
    check("R7 low after acknowledge", {31'b0, irq_out}, 32'h0);
    bus_write(8'h04, 32'h0);
    bus_write(8'h54, 32'h0);
  endtask

  task automatic t_readback_holes();
    logic [31:0] v;
    bus_write(8'h54, 32'hA5C3_0F19);
    bus_read(8'h54, v); check("R9 enable readback next cycle", v, 32'hA5C3_0F19);
    bus_write(8'h58, 32'h0000_0000);
    bus_read(8'h58, v); check("R2 R9 polarity readback", v, 32'h0);
    bus_write(8'h08, 32'hFFFF_FFFF);
    bus_write(8'h55, 32'hFFFF_FFFF);
    bus_read(8'h08, v); check("R10 hole reads zero", v, 32'h0);
    bus_read(8'h54, v); check("R10 enable untouched by hole write", v, 32'hA5C3_0F19);
    bus_read(8'h58, v); check("R10 polarity untouched", v, 32'h0);
    bus_read(8'h50, v); check("R10 pending untouched", v, 32'h0);
    bus_write(8'h54, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mapping_sync();
    t_sync_latency();
    t_polarity();
    t_clear_partial();
    t_collision();
    t_cascade();
    t_readback_holes();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule